// File: doc/BRIEF.md
# UART Receive Buffer with Fill-Level Interrupt

This block sits between a UART receive shift register and the host. Each time the deserializer completes a character it offers a 9-bit word with a one-cycle valid strobe. The block decides whether to keep the word, stores kept words in a small first-in first-out queue, and gives the host a read strobe, the oldest word, a data-available flag and an overrun flag that the host can clear.

An interrupt pulse tells the host when to read. A 2-bit mode input selects the trigger:
- `2'b0x` fires on every character stored.
- `2'b10` fires when a store brings the queue to three quarters of its depth (three characters at the default depth of four).
- `2'b11` fires when a store fills the queue.

When 9-bit mode and address detection are both on, only words whose bit 8 is 1 are kept. Address detection has no effect in 8-bit mode.

Queue occupancy is tracked by a fill-state machine with three states:
- `ST_EMPTY`: no words stored.
- `ST_PART`: between one and depth−1 words stored.
- `ST_FULL`: depth words stored.

Its transitions are:
- fill: `ST_EMPTY`→`ST_PART` on a store.
- top-up: `ST_PART`→`ST_FULL` when the count after the cycle reaches the depth.
- drain: `ST_PART`→`ST_EMPTY` when the count after the cycle is zero.
- release: `ST_FULL`→`ST_PART` on a read with no store.

Every other case holds the state. This includes a read and a store in the same cycle.

Top module: `rxq_buffer`

## Requirements
- R1: After reset `data_avail`, `ovr_flag` and `irq` are 0 and `rd_data` is 0.
- R2: Stored words are read back in arrival order. `rd_data` shows the oldest word while the queue is not empty, and a cycle with `rd_en` high removes it. The queue holds DEPTH (4) words.
- R3: A word accepted while the queue is full and `rd_en` is low is dropped. `ovr_flag` is 1 from the next cycle on, and the stored words are unchanged.
- R4: `ovr_clr` clears `ovr_flag` in the next cycle. If a drop happens in the same cycle as `ovr_clr`, the flag is set.
- R5: With `irq_mode` 2'b00 or 2'b01, `irq` is high for exactly the one cycle after each stored word.
- R6: With `irq_mode` 2'b10, `irq` pulses for one cycle after a store that leaves the count at DEPTH*3/4 (3), and at no other time.
- R7: With `irq_mode` 2'b11, `irq` pulses for one cycle after a store that leaves the count at DEPTH (4), and at no other time.
- R8: With `nine_bit_en`=1 and `addr_det_en`=1, a word whose bit 8 is 0 is discarded. It is not stored, does not raise `irq`, and does not set `ovr_flag`.
- R9: With `nine_bit_en`=0, `addr_det_en` has no effect. Every valid word is kept, and its bit 8 is stored as 0.
- R10: `rd_en` on an empty queue returns `rd_data` 0 and changes nothing.
- R11: A store and a read in the same cycle leave the count unchanged. When the queue is full, that store is kept with no overrun. The interrupt is judged on the count after the cycle.
- R12: `data_avail` is 1 exactly when the queue holds at least one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 9 | Word from the receive shift register |
| rx_valid | input | 1 | One-cycle strobe: `rx_word` is complete |
| irq_mode | input | 2 | Interrupt trigger select |
| nine_bit_en | input | 1 | 9-bit character mode |
| addr_det_en | input | 1 | Keep only address words (bit 8 set) in 9-bit mode |
| rd_en | input | 1 | Host read: remove oldest word |
| rd_data | output | 9 | Oldest stored word, 0 when empty |
| data_avail | output | 1 | Queue not empty |
| ovr_clr | input | 1 | Host clear of the overrun flag |
| ovr_flag | output | 1 | Sticky overrun indication |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its defaults: DEPTH 4 and WIDTH 9. At this depth the three-quarter trigger falls on the third word and the full trigger on the fourth. Five stores are enough to reach the overrun path, the full-queue read-plus-store case and the set-over-clear priority of the overrun flag. The nine-bit width lets the same run exercise address filtering and the masking of bit 8 in 8-bit mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } fill_st_e;

    localparam logic [1:0] MODE_FULL = 2'b11;
    localparam logic [1:0] MODE_3Q   = 2'b10;

endpackage

// File: rtl/rxq_filter.sv
module rxq_filter #(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] word_i,
    input  logic             valid_i,
    input  logic             nine_bit_i,
    input  logic             addr_det_i,
    output logic             accept_o,
    output logic [WIDTH-1:0] word_o
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        word_o = word_i;
        if (!nine_bit_i) begin
            word_o[MSB] = 1'b0;
        end
        accept_o = valid_i && (!(nine_bit_i && addr_det_i) || word_i[MSB]);
    end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 9,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             avail_o,
    output logic             full_o,
    output logic [CW-1:0]    count_next_o
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count_q, count_d;
    fill_st_e         state_q, state_d;
    logic             do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_pop  = pop_i && (state_q != ST_EMPTY);
    assign do_push = push_i && ((state_q != ST_FULL) || do_pop);

    always_comb begin
        count_d = count_q;
        unique case ({do_push, do_pop})
            2'b10:   count_d = count_q + 1'b1;
            2'b01:   count_d = count_q - 1'b1;
            default: count_d = count_q;
        endcase
    end
    assign count_next_o = count_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (do_push) state_d = (count_d == CMAX) ? ST_FULL : ST_PART;
            ST_PART: begin
                if (count_d == CMAX)      state_d = ST_FULL;
                else if (count_d == '0)   state_d = ST_EMPTY;
            end
            ST_FULL:  if (do_pop && !do_push) state_d = (count_d == '0) ? ST_EMPTY : ST_PART;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            count_q <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata_i;
    end

    // outputs
    always_comb begin
        avail_o = 1'b0;
        full_o  = 1'b0;
        rdata_o = '0;
        unique case (state_q)
            ST_EMPTY: ;
            ST_PART:  begin avail_o = 1'b1; rdata_o = mem[rd_ptr]; end
            ST_FULL:  begin avail_o = 1'b1; full_o = 1'b1; rdata_o = mem[rd_ptr]; end
            default:  ;
        endcase
    end

    p_hold_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !pop_i) |=> (state_q == ST_FULL));
    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !push_i) |=> (state_q == ST_EMPTY && rdata_o == '0));
    p_swap_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && do_pop) |=> $stable(count_q));
    p_avail_r12: assert property (@(posedge clk) disable iff (!rst_n)
        avail_o == (count_q != '0));
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          push_i,
    input  logic [CW-1:0] count_next_i,
    output logic          irq_o
);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_3Q   = CW'((DEPTH * 3) / 4);

    logic fire;

    always_comb begin
        fire = 1'b0;
        if (push_i) begin
            unique case (mode_i)
                MODE_FULL: fire = (count_next_i == LVL_FULL);
                MODE_3Q:   fire = (count_next_i == LVL_3Q);
                default:   fire = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= fire;
    end

    p_full_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && mode_i == MODE_FULL && count_next_i != LVL_FULL) |=> !irq_o);
endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rx_word,
    input  logic             rx_valid,
    input  logic [1:0]       irq_mode,
    input  logic             nine_bit_en,
    input  logic             addr_det_en,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             data_avail,
    input  logic             ovr_clr,
    output logic             ovr_flag,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             accept, full, fifo_push, drop;
    logic [WIDTH-1:0] kept_word;
    logic [CW-1:0]    count_next;

    rxq_filter #(.WIDTH(WIDTH)) u_filter (
        .word_i     (rx_word),
        .valid_i    (rx_valid),
        .nine_bit_i (nine_bit_en),
        .addr_det_i (addr_det_en),
        .accept_o   (accept),
        .word_o     (kept_word)
    );

    assign drop      = accept && full && !rd_en;
    assign fifo_push = accept && !drop;

    rxq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (fifo_push),
        .pop_i        (rd_en),
        .wdata_i      (kept_word),
        .rdata_o      (rd_data),
        .avail_o      (data_avail),
        .full_o       (full),
        .count_next_o (count_next)
    );

    rxq_irq #(.DEPTH(DEPTH)) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (irq_mode),
        .push_i       (fifo_push),
        .count_next_i (count_next),
        .irq_o        (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_flag <= 1'b0;
        else if (drop)    ovr_flag <= 1'b1;
        else if (ovr_clr) ovr_flag <= 1'b0;
    end

    p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr_flag);
    p_ovr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_clr && !drop) |=> !ovr_flag);
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(fifo_push));
    p_addr_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && nine_bit_en && addr_det_en && !rx_word[WIDTH-1]) |-> !fifo_push);
endmodule

// File: tb/rxq_buffer_tb.sv
module rxq_buffer_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] rx_word;
    logic       rx_valid, nine_bit_en, addr_det_en, rd_en, ovr_clr;
    logic [1:0] irq_mode;
    logic [8:0] rd_data;
    logic       data_avail, ovr_flag, irq;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;

    always #2 clk = ~clk;

    rxq_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
        .irq_mode(irq_mode), .nine_bit_en(nine_bit_en), .addr_det_en(addr_det_en),
        .rd_en(rd_en), .rd_data(rd_data), .data_avail(data_avail),
        .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .irq(irq)
    );

    typedef struct packed {
        logic       v;
        logic [8:0] w;
        logic       r;
        logic [8:0] e_data;
        logic       e_avail;
        logic       e_irq;
        logic       e_ovr;
    } vec_t;

    // mode 00, 9-bit on, address detect off
    localparam vec_t VECS [9] = '{
        '{1'b1, 9'h101, 1'b0, 9'h101, 1'b1, 1'b1, 1'b0},
        '{1'b1, 9'h022, 1'b0, 9'h101, 1'b1, 1'b1, 1'b0},
        '{1'b0, 9'h000, 1'b0, 9'h101, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'h000, 1'b1, 9'h022, 1'b1, 1'b0, 1'b0},
        '{1'b1, 9'h033, 1'b1, 9'h033, 1'b1, 1'b1, 1'b0},
        '{1'b0, 9'h000, 1'b1, 9'h000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 9'h000, 1'b1, 9'h000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 9'h1FF, 1'b0, 9'h1FF, 1'b1, 1'b1, 1'b0},
        '{1'b0, 9'h000, 1'b1, 9'h000, 1'b0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [8:0] w, input logic r, input logic c);
        rx_valid = v; rx_word = w; rd_en = r; ovr_clr = c;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rx_word = '0; rd_en = 1'b0; ovr_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; rx_valid = 1'b0; rx_word = '0; rd_en = 1'b0; ovr_clr = 1'b0;
        irq_mode = 2'b00; nine_bit_en = 1'b1; addr_det_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 avail", data_avail, 0);
        check("R1 ovr", ovr_flag, 0);
        check("R1 irq", irq, 0);
        check("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;

        // table walk: R2 R5 R10 R11 R12
        foreach (VECS[i]) begin
            cyc(VECS[i].v, VECS[i].w, VECS[i].r, 1'b0);
            check($sformatf("R2 vec%0d data", i), rd_data, VECS[i].e_data);
            check($sformatf("R12 vec%0d avail", i), data_avail, VECS[i].e_avail);
            check($sformatf("R5 vec%0d irq", i), irq, VECS[i].e_irq);
            check($sformatf("R10 vec%0d ovr", i), ovr_flag, VECS[i].e_ovr);
        end

        // R6: three-quarter trigger
        irq_mode = 2'b10;
        for (int k = 0; k < 4; k++) begin
            cyc(1'b1, 9'h010 + 9'(k), 1'b0, 1'b0);
            check($sformatf("R6 push%0d irq", k), irq, (k == 2) ? 1 : 0);
        end
        // R3: overflow
        cyc(1'b1, 9'h0EE, 1'b0, 1'b0);
        check("R3 ovr set", ovr_flag, 1);
        check("R3 no irq", irq, 0);
        for (int k = 0; k < 4; k++) begin
            check($sformatf("R3 R2 order%0d", k), rd_data, 9'h010 + 9'(k));
            cyc(1'b0, 9'h000, 1'b1, 1'b0);
        end
        check("R3 empty after drain", data_avail, 0);
        check("R3 ovr sticky", ovr_flag, 1);
        // R4: clear
        cyc(1'b0, 9'h000, 1'b0, 1'b1);
        check("R4 clear", ovr_flag, 0);

        // R7: full trigger
        irq_mode = 2'b11;
        for (int k = 0; k < 4; k++) begin
            cyc(1'b1, 9'h020 + 9'(k), 1'b0, 1'b0);
            check($sformatf("R7 push%0d irq", k), irq, (k == 3) ? 1 : 0);
        end
        // R11: full with read and store together
        cyc(1'b1, 9'h0AB, 1'b1, 1'b0);
        check("R11 no ovr", ovr_flag, 0);
        check("R11 irq on count after", irq, 1);
        check("R11 head advanced", rd_data, 9'h021);
        // R4: drop and clear in the same cycle
        cyc(1'b1, 9'h0CD, 1'b0, 1'b1);
        check("R4 set wins", ovr_flag, 1);
        check("R4 contents kept", rd_data, 9'h021);
        for (int k = 0; k < 4; k++) cyc(1'b0, 9'h000, 1'b1, 1'b0);
        check("R11 last kept", data_avail, 0);
        cyc(1'b0, 9'h000, 1'b0, 1'b1);

        // R8: address filter
        irq_mode = 2'b00; addr_det_en = 1'b1;
        cyc(1'b1, 9'h055, 1'b0, 1'b0);
        check("R8 data dropped", data_avail, 0);
        check("R8 no irq", irq, 0);
        check("R8 no ovr", ovr_flag, 0);
        cyc(1'b1, 9'h1AA, 1'b0, 1'b0);
        check("R8 address kept", rd_data, 9'h1AA);
        check("R8 irq", irq, 1);
        // R9: 8-bit mode ignores address detect, masks bit 8
        nine_bit_en = 1'b0;
        cyc(1'b1, 9'h0BB, 1'b0, 1'b0);
        cyc(1'b1, 9'h1CC, 1'b0, 1'b0);
        cyc(1'b0, 9'h000, 1'b1, 1'b0);
        check("R9 kept bit8=0 word", rd_data, 9'h0BB);
        cyc(1'b0, 9'h000, 1'b1, 1'b0);
        check("R9 masked bit8", rd_data, 9'h0CC);
        cyc(1'b0, 9'h000, 1'b1, 1'b0);
        check("R10 empty read", rd_data, 0);

        // R1: reset in mid-run
        cyc(1'b1, 9'h011, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 re-reset avail", data_avail, 0);
        check("R1 re-reset irq", irq, 0);
        rst_n = 1'b1;
        finish_run();
    end
endmodule